// File: doc/BRIEF.md
# Cluster Coherency Control Register File

This block is the software-visible register file of a multicore cluster's coherency controller. It sits on a simple register bus with a byte address, separate read and write strobes, a 32-bit write word and an access size given in bytes. It returns read data one clock after the read strobe. It holds a single enable bit and a 32-bit word of per-core power status bytes. It also reports a read-only configuration word that is built from the core-count parameter.

The power status word can be reached at any of its four byte addresses, with 1, 2 or 4 byte accesses. Writes touch only the byte lanes that the access covers, and lanes that would fall past bit 31 are dropped. Several other offsets are decoded as placeholders that read as zero and ignore writes. These are invalidate-all, the two filter address words and the two access-control words. Every other address behaves the same way. The block raises no bus error and drives no coherency, filtering or power-sequencing logic.

Top module: `coh_ctl_regs`

## Requirements
- R1: After reset the enable bit, the power status word and the read data output are all zero.
- R2: A write to offset 0x00 of any valid size stores bit 0 of the write data as the enable bit. A read of 0x00 returns that bit in bit 0, with zeros above it.
- R3: A read of offset 0x04 returns ((1<<NUM_CORES)-1) in bits 7:4, ORed with NUM_CORES-1 in the low bits. For the default of 4 cores this is 0x000000F3. Writes to 0x04 change nothing.
- R4: A read at offset 0x08+k (k = 0 to 3) returns the power status word shifted right by 8*k bits, with zero fill.
- R5: A write at offset 0x08+k with size S bytes replaces byte lanes k to k+S-1 of the power status word with write-data bytes 0 to S-1. Lanes above 3 are discarded. All other lanes keep their value.
- R6: A write whose size field (3 bits, the byte count) is anything other than 1, 2 or 4 changes no state at any offset.
- R7: Offsets 0x0C, 0x40, 0x44, 0x50 and 0x54, and every address not named in R2 to R5, read as zero. Writes to them change neither the enable bit nor the power status word.
- R8: Read data is registered. It updates on the clock edge that samples the read strobe and holds its value while no read is strobed.
- R9: When a read and a write fall in the same cycle, the read returns the register contents from before that write. The write takes effect for later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_size | input | 3 | Access size in bytes (1, 2 or 4 valid) |
| bus_wdata | input | DATA_W | Write data, least significant byte in lane 0 |
| bus_rdata | output | DATA_W | Registered read data |

## Verification
A read strobe and a write strobe can both be high in one cycle, and they can target the same power status lanes. The bench provokes this by asserting both strobes together at the power word's base address with new data. It expects the registered read data to carry the old word. It then expects a separate later read to show the new word. The same collision is also run at the enable offset, so the capture order is judged on both stored registers.

// File: rtl/coh_ctl_pkg.sv
package coh_ctl_pkg;

   // Decoded target of one bus access
   typedef struct packed {
      logic       ctrl;   // enable bit word
      logic       cfg;    // read-only configuration word
      logic       pwr;    // power status word, any byte address
      logic [1:0] lane;   // byte offset inside the power word
   } coh_sel_t;

   localparam logic [2:0] SZ_BYTE = 3'd1;
   localparam logic [2:0] SZ_HALF = 3'd2;
   localparam logic [2:0] SZ_WORD = 3'd4;

   function automatic logic size_is_legal(input logic [2:0] sz);
      return (sz == SZ_BYTE) || (sz == SZ_HALF) || (sz == SZ_WORD);
   endfunction

   function automatic logic [31:0] cfg_word(input int unsigned cores);
      logic [31:0] w;
      w = ((32'd1 << cores) - 32'd1) << 4;
      w = w | (cores - 1);
      return w;
   endfunction

endpackage

// File: rtl/coh_ctl_decode.sv
module coh_ctl_decode
   import coh_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output coh_sel_t          sel
);
   localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(8'h00);
   localparam logic [ADDR_W-1:0] OFS_CFG  = ADDR_W'(8'h04);
   localparam logic [ADDR_W-3:0] PWR_WORD = (ADDR_W-2)'(2);

   always_comb begin
      sel      = '0;
      sel.ctrl = (addr == OFS_CTRL);
      sel.cfg  = (addr == OFS_CFG);
      sel.pwr  = (addr[ADDR_W-1:2] == PWR_WORD);
      sel.lane = addr[1:0];
   end
endmodule

// File: rtl/coh_ctl_pwr.sv
module coh_ctl_pwr #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        lane,
   input  logic [2:0]        size,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   localparam int unsigned LANES = DATA_W / 8;

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      logic [1:0] src;
      logic       hit;
      logic [7:0] byte_q;

      assign src = 2'(b) - lane;
      assign hit = (lane <= 2'(b)) && (3'(src) < size);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         byte_q <= '0;
         else if (we && hit) byte_q <= wdata[8*src +: 8];
      end

      assign q[8*b +: 8] = byte_q;
   end
endmodule

// File: rtl/coh_ctl_rdmux.sv
module coh_ctl_rdmux
   import coh_ctl_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  coh_sel_t          sel,
   input  logic              en,
   input  logic [DATA_W-1:0] cfg,
   input  logic [DATA_W-1:0] pwr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] rd_next;

   always_comb begin
      rd_next = '0;
      if (sel.ctrl)     rd_next = DATA_W'(en);
      else if (sel.cfg) rd_next = cfg;
      else if (sel.pwr) rd_next = pwr >> {sel.lane, 3'b000};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (rd) rdata <= rd_next;
   end
endmodule

// File: rtl/coh_ctl_regs.sv
module coh_ctl_regs
   import coh_ctl_pkg::*;
#(
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [2:0]        bus_size,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam logic [DATA_W-1:0] CFG_VAL = DATA_W'(cfg_word(NUM_CORES));

   if (NUM_CORES < 1 || NUM_CORES > 4) begin : g_bad_cores
      $error("coh_ctl_regs: NUM_CORES must lie in 1..4");
   end
   if (DATA_W != 32) begin : g_bad_width
      $error("coh_ctl_regs: DATA_W must be 32");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("coh_ctl_regs: ADDR_W must reach offset 0x54");
   end

   coh_sel_t          sel;
   logic              size_ok;
   logic              en_q;
   logic [DATA_W-1:0] pwr_q;

   assign size_ok = size_is_legal(bus_size);

   coh_ctl_decode #(.ADDR_W(ADDR_W)) i_decode (
      .addr (bus_addr),
      .sel  (sel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           en_q <= 1'b0;
      else if (bus_wr && size_ok && sel.ctrl) en_q <= bus_wdata[0];
   end

   coh_ctl_pwr #(.DATA_W(DATA_W)) i_pwr (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bus_wr && size_ok && sel.pwr),
      .lane  (sel.lane),
      .size  (bus_size),
      .wdata (bus_wdata),
      .q     (pwr_q)
   );

   coh_ctl_rdmux #(.DATA_W(DATA_W)) i_rdmux (
      .clk   (clk),
      .rst_n (rst_n),
      .rd    (bus_rd),
      .sel   (sel),
      .en    (en_q),
      .cfg   (CFG_VAL),
      .pwr   (pwr_q),
      .rdata (bus_rdata)
   );
endmodule

// File: rtl/coh_ctl_regs_chk.sv
module coh_ctl_regs_chk #(
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [2:0]        bus_size,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              en_q,
   input logic [DATA_W-1:0] pwr_q
);
   logic legal_sz, hits_en, hits_pwr, quiet_addr;
   assign legal_sz   = (bus_size == 3'd1) || (bus_size == 3'd2) || (bus_size == 3'd4);
   assign hits_en    = (bus_addr == '0);
   assign hits_pwr   = (bus_addr >= ADDR_W'(8'h08)) && (bus_addr <= ADDR_W'(8'h0B));
   assign quiet_addr = !hits_en && !hits_pwr && (bus_addr != ADDR_W'(8'h04));

   AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && hits_en |=> bus_rdata[DATA_W-1:1] == '0);                  // R2
   AST_EN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && hits_en) |=> $stable(en_q));                              // R2
   AST_CFG_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && bus_addr == ADDR_W'(8'h04) |=>
         bus_rdata == DATA_W'((((1 << NUM_CORES) - 1) << 4) | (NUM_CORES - 1))); // R3
   AST_BAD_SIZE_PWR: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && !legal_sz |=> $stable(pwr_q));                              // R6
   AST_BAD_SIZE_EN: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && !legal_sz |=> $stable(en_q));                               // R6
   AST_QUIET_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && quiet_addr |=> bus_rdata == '0);                            // R7
   AST_QUIET_WRITE_PWR: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && hits_pwr) |=> $stable(pwr_q));                            // R7
   AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));                                      // R8
   AST_READ_OLD_EN: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && bus_wr && hits_en |=> bus_rdata[0] == $past(en_q));         // R9
endmodule

bind coh_ctl_regs coh_ctl_regs_chk #(
   .NUM_CORES (NUM_CORES),
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_size  (bus_size),
   .bus_rdata (bus_rdata),
   .en_q      (en_q),
   .pwr_q     (pwr_q)
);

// File: tb/test_coh_ctl_regs.sv
module test_coh_ctl_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_size = 3'd4;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   bit rd_seen = 0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   logic [31:0] m_pwr = '0;   // bench model of the power word
   logic        m_en  = 1'b0; // bench model of the enable bit

   always #5 clk = ~clk;

   coh_ctl_regs i_coh_ctl_regs (
      .clk, .rst_n, .bus_addr, .bus_rd, .bus_wr, .bus_size, .bus_wdata, .bus_rdata
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   // monitor: note read strobes at the edge, compare half a cycle later
   always @(posedge clk) rd_seen <= bus_rd;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R8: unexpected read result %08h expected none", bus_rdata);
         end else begin
            check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
         end
      end
   end

   function automatic logic legal(input logic [2:0] sz);
      return sz == 3'd1 || sz == 3'd2 || sz == 3'd4;
   endfunction

   function automatic void model_write(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
      if (!legal(sz)) return;
      if (a == 8'h00) m_en = d[0];
      if (a >= 8'h08 && a <= 8'h0B) begin
         for (int i = 0; i < int'(sz); i++) begin
            int ln = int'(a - 8'h08) + i;
            if (ln < 4) m_pwr[8*ln +: 8] = d[8*i +: 8];
         end
      end
   endfunction

   function automatic logic [31:0] model_read(input logic [7:0] a);
      if (a == 8'h00) return {31'b0, m_en};
      if (a == 8'h04) return 32'h0000_00F3;
      if (a >= 8'h08 && a <= 8'h0B) return m_pwr >> (8 * int'(a - 8'h08));
      return 32'h0;
   endfunction

   task automatic access(input bit rd, input bit wr, input logic [7:0] a,
                         input logic [2:0] sz, input logic [31:0] d, input string tag);
      @(negedge clk);
      bus_addr = a; bus_rd = rd; bus_wr = wr; bus_size = sz; bus_wdata = d;
      if (rd) begin
         exp_q.push_back(model_read(a)); // value before any same-cycle write
         tag_q.push_back(tag);
      end
      if (wr) model_write(a, sz, d);
      @(negedge clk);
      bus_rd = 0; bus_wr = 0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
      access(0, 1, a, sz, d, "");
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      access(1, 0, a, 3'd4, 0, tag);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] quiet[6] = '{8'h0C, 8'h40, 8'h44, 8'h50, 8'h54, 8'h01};
      repeat (3) @(negedge clk);
      check("R1 rdata after reset", bus_rdata, 32'h0);
      rst_n = 1'b1;
      rd(8'h00, "R1 enable reset");
      rd(8'h08, "R1 power reset");

      // R2 enable bit
      wr(8'h00, 3'd4, 32'hFFFF_FFFE);
      rd(8'h00, "R2 bit0 clear");
      wr(8'h00, 3'd1, 32'h0000_0003);
      rd(8'h00, "R2 bit0 set only");

      // R3 configuration
      rd(8'h04, "R3 cfg value");
      wr(8'h04, 3'd4, 32'hFFFF_FFFF);
      rd(8'h04, "R3 cfg after write");

      // R4 shifted reads
      wr(8'h08, 3'd4, 32'h1122_3344);
      for (int k = 0; k < 4; k++) rd(8'h08 + 8'(k), "R4 shifted read");

      // R5 lane writes
      wr(8'h09, 3'd1, 32'hFFFF_FFAB);
      rd(8'h08, "R5 byte at lane1");
      wr(8'h0A, 3'd2, 32'h1234_CDEF);
      rd(8'h08, "R5 half at lane2");
      wr(8'h0A, 3'd4, 32'h9988_7766);
      rd(8'h08, "R5 word at lane2 truncated");
      wr(8'h0B, 3'd2, 32'h0000_5544);
      rd(8'h08, "R5 half at lane3 truncated");
      rd(8'h0B, "R5 top byte");

      // R6 illegal sizes
      foreach (quiet[i]) begin end
      for (int s = 0; s < 8; s++) begin
         if (!legal(3'(s))) begin
            wr(8'h08, 3'(s), 32'h0);
            wr(8'h00, 3'(s), 32'h0);
         end
      end
      rd(8'h08, "R6 power unchanged");
      rd(8'h00, "R6 enable unchanged");

      // R7 read-as-zero offsets
      foreach (quiet[i]) begin
         wr(quiet[i], 3'd4, 32'hFFFF_FFFF);
         rd(quiet[i], "R7 quiet offset reads zero");
      end
      rd(8'h08, "R7 power untouched");
      rd(8'h00, "R7 enable untouched");

      // R8 hold without read strobe
      rd(8'h04, "R8 load cfg");
      wr(8'h08, 3'd4, 32'hA5A5_A5A5);
      repeat (3) @(negedge clk);
      check("R8 rdata held", bus_rdata, 32'h0000_00F3);

      // R9 same-cycle read and write
      access(1, 1, 8'h08, 3'd4, 32'h0000_0000, "R9 power read sees old");
      rd(8'h08, "R9 power write landed");
      access(1, 1, 8'h00, 3'd4, 32'h0000_0000, "R9 enable read sees old");
      rd(8'h00, "R9 enable write landed");

      repeat (2) @(negedge clk);
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R8: actual %0d pending reads expected 0", exp_q.size());
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule